// File: doc/BRIEF.md
# Potentiometer Command Slave on a Two-Wire Serial Bus

This block is the serial-bus front end of a digitally set potentiometer. It watches the bus clock and data lines, which arrive already synchronized to the system clock. Any change it sees on either line is an edge to the block. It answers only its own 7-bit bus address, which the pin-strap logic supplies as a ready value. After a write address it takes an instruction byte. Depending on the command, it then takes data bytes and sends one-cycle requests to the setting sequencer. Those requests cover wiper writes, nonvolatile writes, write-protect changes, and copies between the wiper and the nonvolatile cell. The only thing it drives onto the bus is a pull-low enable for the open-drain data line.

The block keeps a read pointer, and each accepted instruction moves that pointer to the register the instruction names. A later read transaction then shifts out the selected byte. The sources are the live wiper value, the nonvolatile value, the write-protect flag or one of the two factory tolerance bytes.

The control state machine has these states:
- IDLE: the bus is free.
- RX_ADDR: receiving the address byte.
- ACK_ADDR: acknowledging the address.
- RX_INSTR: receiving the instruction byte.
- ACK_INSTR: acknowledging the instruction.
- RX_DATA: receiving a data byte.
- ACK_DATA: acknowledging a data byte.
- TX_DATA: sending a read byte.
- TX_ACK: watching for the master's acknowledge.
- WAIT_STOP: the transfer is ignored until the next START or STOP.

The transitions are:
- START moves any state to RX_ADDR.
- STOP moves any state to IDLE, and issues a store or restore request if one is pending.
- A matched address moves RX_ADDR to ACK_ADDR. A mismatch moves it to WAIT_STOP.
- ACK_ADDR moves to RX_INSTR for a write, or to TX_DATA for a read.
- A valid instruction moves RX_INSTR to ACK_INSTR. An invalid one moves it to WAIT_STOP.
- ACK_INSTR moves to RX_DATA.
- RX_DATA moves to ACK_DATA for a command that takes data, or to WAIT_STOP for one that does not.
- ACK_DATA moves back to RX_DATA.
- TX_DATA moves to TX_ACK after eight bits.
- On a master acknowledge, TX_ACK moves to TX_DATA with the next byte. On a no-acknowledge, it moves to WAIT_STOP.

Top module: `potcmd_i2c_slave`

## Requirements
- R1: START is SDA falling while SCL is high. It sends the slave to the address phase from any state, including after a rejected address, and clears any pending store or restore.
- R2: The address byte is sampled on SCL rising edges, MSB first, with the R/W bit last (1 = read). The slave pulls SDA low through the ninth clock only when the upper seven bits equal `dev_addr`. Otherwise it pulls nothing until the next START or STOP.
- R3: The instruction byte is read as command = bits 7:5 and location = bits 4:0. The accepted codes are:
  - 000, 001 and 010 with location 0 (wiper, nonvolatile, write protect).
  - 001 with location 11110 or 11111 (tolerance high or low byte).
  - 110 and 101 with location 0 (store, restore).
  
  Any other instruction is not acknowledged. It issues no request, leaves the read pointer as it was, and causes no acknowledge for the rest of the transfer.
- R4: After command 000, each acknowledged data byte issues exactly one single-cycle `req_valid` with `req_op` = 1 (wiper write) and the byte as `req_data`. This happens again for every further byte until STOP.
- R5: After command 001 with location 0, each data byte issues `req_op` = 2 (nonvolatile write) with the byte as data.
- R6: After command 010, only bit 0 of each data byte counts. A 1 issues `req_op` = 3 (protect on) and a 0 issues `req_op` = 4 (protect off), with `req_data` equal to that bit.
- R7: Store (110) and restore (101) issue `req_op` = 5 or 6 with data 0, one cycle after the STOP that ends the transfer. If a repeated START comes first, no request is issued.
- R8: A read returns the register chosen by the latest accepted instruction, MSB first, with the bit changing on SCL falling edges. The write-protect register reads as seven zeros above the flag.
- R9: After a tolerance-high instruction, sending the high byte moves the pointer to the tolerance-low location. A second byte in the same read, and later reads, return the low byte.
- R10: When the master answers a read byte with no-acknowledge, the slave stops driving SDA until the next START.
- R11: A STOP in the middle of a data byte aborts it with no request.
- R12: After reset no request is pending, SDA is released, and the read pointer selects the wiper register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data (wired line level) |
| dev_addr | input | ADDR_W | Slave address of this device |
| wiper_val | input | DATA_W | Current wiper setting, for reads |
| nv_val | input | DATA_W | Current nonvolatile value, for reads |
| wp_flag | input | 1 | Current write-protect flag, for reads |
| tol_hi | input | DATA_W | Tolerance sign and integer byte |
| tol_lo | input | DATA_W | Tolerance fraction byte |
| sda_pull | output | 1 | Pull the data line low when 1 |
| req_valid | output | 1 | Single-cycle request strobe |
| req_op | output | 3 | Request kind (1 wiper, 2 nonvolatile, 3 protect on, 4 protect off, 5 store, 6 restore) |
| req_data | output | DATA_W | Request data |

## Verification
The bound checker watches four things on every cycle:
- Requests are single-cycle strobes.
- Write-type requests appear only while SCL is low.
- Store and restore requests follow a detected STOP.
- The pull-low enable starts only while SCL is low and never moves during an SCL high phase.

Only the bench scenarios can show the byte-level meaning. That covers which addresses and instruction codes are acknowledged, what data each request carries, and what the read pointer selects across transactions, including the tolerance advance. It also covers dropping a store or restore at a repeated START and the silent abort on a mid-byte STOP.

// File: rtl/potcmd_pkg.sv
package potcmd_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_WIPER_WR = 3'd1,
        OP_NV_WR    = 3'd2,
        OP_WP_SET   = 3'd3,
        OP_WP_CLR   = 3'd4,
        OP_STORE    = 3'd5,
        OP_RESTORE  = 3'd6
    } req_op_t;

    typedef enum logic [2:0] {
        PTR_WIPER,
        PTR_NV,
        PTR_WP,
        PTR_TOL_HI,
        PTR_TOL_LO
    } ptr_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX_ADDR,
        ST_ACK_ADDR,
        ST_RX_INSTR,
        ST_ACK_INSTR,
        ST_RX_DATA,
        ST_ACK_DATA,
        ST_TX_DATA,
        ST_TX_ACK,
        ST_WAIT_STOP
    } state_t;

endpackage

// File: rtl/potcmd_bus_cond.sv
module potcmd_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_i;
            sda_d <= sda_i;
        end
    end

    assign scl_rise  =  scl_i & ~scl_d;
    assign scl_fall  = ~scl_i &  scl_d;
    assign start_det =  scl_i &  scl_d & ~sda_i &  sda_d;
    assign stop_det  =  scl_i &  scl_d &  sda_i & ~sda_d;
endmodule

// File: rtl/potcmd_instr_dec.sv
module potcmd_instr_dec
    import potcmd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CMD_W  = 3
) (
    input  logic [DATA_W-1:0] instr,
    output logic              ok,
    output logic              ptr_load,
    output ptr_t              ptr_sel,
    output logic              takes_data,
    output req_op_t           data_op,
    output req_op_t           sr_op
);
    localparam int LOW_W = DATA_W - CMD_W;
    localparam logic [LOW_W-1:0] LOC_ZERO   = '0;
    localparam logic [LOW_W-1:0] LOC_TOL_LO = '1;
    localparam logic [LOW_W-1:0] LOC_TOL_HI = LOC_TOL_LO - 1'b1;

    logic [CMD_W-1:0] cmd;
    logic [LOW_W-1:0] loc;

    assign cmd = instr[DATA_W-1 -: CMD_W];
    assign loc = instr[LOW_W-1:0];

    always_comb begin
        ok         = 1'b0;
        ptr_load   = 1'b0;
        ptr_sel    = PTR_WIPER;
        takes_data = 1'b0;
        data_op    = OP_NONE;
        sr_op      = OP_NONE;
        unique case (cmd)
            3'b000: if (loc == LOC_ZERO) begin
                ok = 1'b1; ptr_load = 1'b1; ptr_sel = PTR_WIPER;
                takes_data = 1'b1; data_op = OP_WIPER_WR;
            end
            3'b001: begin
                if (loc == LOC_ZERO) begin
                    ok = 1'b1; ptr_load = 1'b1; ptr_sel = PTR_NV;
                    takes_data = 1'b1; data_op = OP_NV_WR;
                end else if (loc == LOC_TOL_HI) begin
                    ok = 1'b1; ptr_load = 1'b1; ptr_sel = PTR_TOL_HI;
                    takes_data = 1'b1;
                end else if (loc == LOC_TOL_LO) begin
                    ok = 1'b1; ptr_load = 1'b1; ptr_sel = PTR_TOL_LO;
                    takes_data = 1'b1;
                end
            end
            3'b010: if (loc == LOC_ZERO) begin
                ok = 1'b1; ptr_load = 1'b1; ptr_sel = PTR_WP;
                takes_data = 1'b1; data_op = OP_WP_SET;
            end
            3'b110: if (loc == LOC_ZERO) begin
                ok = 1'b1; sr_op = OP_STORE;
            end
            3'b101: if (loc == LOC_ZERO) begin
                ok = 1'b1; sr_op = OP_RESTORE;
            end
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/potcmd_rd_mux.sv
module potcmd_rd_mux
    import potcmd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  ptr_t              ptr,
    input  logic [DATA_W-1:0] wiper_val,
    input  logic [DATA_W-1:0] nv_val,
    input  logic              wp_flag,
    input  logic [DATA_W-1:0] tol_hi,
    input  logic [DATA_W-1:0] tol_lo,
    output logic [DATA_W-1:0] rd_byte
);
    always_comb begin
        unique case (ptr)
            PTR_WIPER:  rd_byte = wiper_val;
            PTR_NV:     rd_byte = nv_val;
            PTR_WP:     rd_byte = {{(DATA_W-1){1'b0}}, wp_flag};
            PTR_TOL_HI: rd_byte = tol_hi;
            PTR_TOL_LO: rd_byte = tol_lo;
            default:    rd_byte = '0;
        endcase
    end
endmodule

// File: rtl/potcmd_i2c_slave.sv
module potcmd_i2c_slave
    import potcmd_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int CMD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [DATA_W-1:0] wiper_val,
    input  logic [DATA_W-1:0] nv_val,
    input  logic              wp_flag,
    input  logic [DATA_W-1:0] tol_hi,
    input  logic [DATA_W-1:0] tol_lo,
    output logic              sda_pull,
    output logic              req_valid,
    output logic [2:0]        req_op,
    output logic [DATA_W-1:0] req_data
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(DATA_W);

    logic scl_rise, scl_fall, start_det, stop_det;

    state_t            state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              rw_bit;
    logic              ack_seen;
    ptr_t              ptr;
    req_op_t           data_op_q;
    req_op_t           sr_op_q;
    logic              takes_q;
    req_op_t           req_op_q;

    logic              dec_ok, dec_ptr_load, dec_takes;
    ptr_t              dec_ptr;
    req_op_t           dec_data_op, dec_sr_op;
    logic [DATA_W-1:0] rd_byte;

    potcmd_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    potcmd_instr_dec #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_dec (
        .instr      (rx_sh),
        .ok         (dec_ok),
        .ptr_load   (dec_ptr_load),
        .ptr_sel    (dec_ptr),
        .takes_data (dec_takes),
        .data_op    (dec_data_op),
        .sr_op      (dec_sr_op)
    );

    potcmd_rd_mux #(.DATA_W(DATA_W)) u_mux (
        .ptr       (ptr),
        .wiper_val (wiper_val),
        .nv_val    (nv_val),
        .wp_flag   (wp_flag),
        .tol_hi    (tol_hi),
        .tol_lo    (tol_lo),
        .rd_byte   (rd_byte)
    );

    // State register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rw_bit    <= 1'b0;
            ack_seen  <= 1'b0;
            ptr       <= PTR_WIPER;
            data_op_q <= OP_NONE;
            sr_op_q   <= OP_NONE;
            takes_q   <= 1'b0;
            req_valid <= 1'b0;
            req_op_q  <= OP_NONE;
            req_data  <= '0;
        end else begin
            req_valid <= 1'b0;
            if (start_det) begin
                state   <= ST_RX_ADDR;
                bit_cnt <= '0;
                sr_op_q <= OP_NONE;
            end else if (stop_det) begin
                if (sr_op_q != OP_NONE) begin
                    req_valid <= 1'b1;
                    req_op_q  <= sr_op_q;
                    req_data  <= '0;
                end
                sr_op_q <= OP_NONE;
                state   <= ST_IDLE;
            end else if (scl_rise) begin
                unique case (state)
                    ST_RX_ADDR, ST_RX_INSTR, ST_RX_DATA: begin
                        rx_sh   <= {rx_sh[DATA_W-2:0], sda_i};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_TX_DATA: bit_cnt <= bit_cnt + 1'b1;
                    ST_TX_ACK: begin
                        if (sda_i) state <= ST_WAIT_STOP;
                        else       ack_seen <= 1'b1;
                    end
                    default: ;
                endcase
            end else if (scl_fall) begin
                unique case (state)
                    ST_RX_ADDR: if (bit_cnt == BYTE_DONE) begin
                        if (rx_sh[DATA_W-1 -: ADDR_W] == dev_addr) begin
                            rw_bit <= rx_sh[0];
                            state  <= ST_ACK_ADDR;
                        end else begin
                            state  <= ST_WAIT_STOP;
                        end
                    end
                    ST_ACK_ADDR: begin
                        bit_cnt <= '0;
                        if (rw_bit) begin
                            tx_sh <= rd_byte;
                            if (ptr == PTR_TOL_HI) ptr <= PTR_TOL_LO;
                            state <= ST_TX_DATA;
                        end else begin
                            state <= ST_RX_INSTR;
                        end
                    end
                    ST_RX_INSTR: if (bit_cnt == BYTE_DONE) begin
                        if (dec_ok) begin
                            if (dec_ptr_load) ptr <= dec_ptr;
                            data_op_q <= dec_data_op;
                            sr_op_q   <= dec_sr_op;
                            takes_q   <= dec_takes;
                            state     <= ST_ACK_INSTR;
                        end else begin
                            state     <= ST_WAIT_STOP;
                        end
                    end
                    ST_ACK_INSTR, ST_ACK_DATA: begin
                        bit_cnt <= '0;
                        state   <= ST_RX_DATA;
                    end
                    ST_RX_DATA: if (bit_cnt == BYTE_DONE) begin
                        if (takes_q) begin
                            state <= ST_ACK_DATA;
                            if (data_op_q == OP_WP_SET) begin
                                req_valid <= 1'b1;
                                req_op_q  <= rx_sh[0] ? OP_WP_SET : OP_WP_CLR;
                                req_data  <= {{(DATA_W-1){1'b0}}, rx_sh[0]};
                            end else if (data_op_q != OP_NONE) begin
                                req_valid <= 1'b1;
                                req_op_q  <= data_op_q;
                                req_data  <= rx_sh;
                            end
                        end else begin
                            state <= ST_WAIT_STOP;
                        end
                    end
                    ST_TX_DATA: begin
                        if (bit_cnt == BYTE_DONE) begin
                            ack_seen <= 1'b0;
                            state    <= ST_TX_ACK;
                        end else begin
                            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                        end
                    end
                    ST_TX_ACK: if (ack_seen) begin
                        tx_sh   <= rd_byte;
                        bit_cnt <= '0;
                        if (ptr == PTR_TOL_HI) ptr <= PTR_TOL_LO;
                        state   <= ST_TX_DATA;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_ACK_ADDR, ST_ACK_INSTR, ST_ACK_DATA: sda_pull = 1'b1;
            ST_TX_DATA: sda_pull = ~tx_sh[DATA_W-1];
            default:    sda_pull = 1'b0;
        endcase
    end

    assign req_op = req_op_q;
endmodule

// File: rtl/potcmd_i2c_slave_chk.sv
module potcmd_i2c_slave_chk
    import potcmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_pull,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic       stop_det
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R12: reset leaves the bus released and no request
    p_reset_quiet_r12: assert property (@(posedge clk)
        !rst_n |=> (!req_valid && !sda_pull));

    // R4: every request is a single-cycle strobe
    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R4: byte-driven requests arise while SCL is low
    p_wr_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 3'(OP_STORE) && req_op != 3'(OP_RESTORE)) |-> !scl_i);

    // R7: store and restore follow a detected STOP
    p_sr_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && req_valid && (req_op == 3'(OP_STORE) || req_op == 3'(OP_RESTORE)))
            |-> $past(stop_det));

    // R8: the slave never moves SDA during an SCL high phase
    p_pull_stable_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && scl_i && $past(scl_i)) |-> $stable(sda_pull));

    // R2: pulling starts only while SCL is low
    p_pull_rise_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(sda_pull)) |-> !scl_i);
endmodule

bind potcmd_i2c_slave potcmd_i2c_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_pull  (sda_pull),
    .req_valid (req_valid),
    .req_op    (req_op),
    .stop_det  (stop_det)
);

// File: tb/potcmd_i2c_slave_bench.sv
module potcmd_i2c_slave_bench;
    import potcmd_pkg::*;

    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_pull;
    logic       req_valid;
    logic [2:0] req_op;
    logic [7:0] req_data;

    logic [6:0] my_addr = 7'h2C;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R12";
    logic  exp_on = 1'b0;
    logic  exp_pull = 1'b0;
    logic [2:0] q_op[$];
    logic [7:0] q_dat[$];

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    potcmd_i2c_slave u_potcmd_i2c_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .dev_addr  (my_addr),
        .wiper_val (8'hA5),
        .nv_val    (8'h3C),
        .wp_flag   (1'b1),
        .tol_hi    (8'h1C),
        .tol_lo    (8'h0F),
        .sda_pull  (sda_pull),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_data  (req_data)
    );

    // Per-clock reference comparison
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_on) begin
                checks++;
                if (sda_pull !== exp_pull) begin
                    errors++;
                    $display("FAIL %s sda_pull actual %0b expected %0b", cur_req, sda_pull, exp_pull);
                end
            end
            if (req_valid) begin
                checks++;
                if (q_op.size() == 0) begin
                    errors++;
                    $display("FAIL %s request actual op %0d data %h expected none", cur_req, req_op, req_data);
                end else begin
                    logic [2:0] eo;
                    logic [7:0] ed;
                    eo = q_op.pop_front();
                    ed = q_dat.pop_front();
                    if (req_op !== eo || req_data !== ed) begin
                        errors++;
                        $display("FAIL %s request actual op %0d data %h expected op %0d data %h",
                                 cur_req, req_op, req_data, eo, ed);
                    end
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic scl_pulse(input logic drv, input logic ep);
        m_sda = drv;
        wait_cyc(Q);
        m_scl = 1'b1;
        wait_cyc(1);
        exp_pull = ep;
        exp_on = 1'b1;
        wait_cyc(Q - 1);
        exp_on = 1'b0;
        m_scl = 1'b0;
        wait_cyc(2);
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        wait_cyc(Q);
        m_scl = 1'b1;
        wait_cyc(Q);
        m_sda = 1'b0;
        wait_cyc(Q);
        m_scl = 1'b0;
        wait_cyc(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        wait_cyc(Q);
        m_scl = 1'b1;
        wait_cyc(1);
        exp_pull = 1'b0;
        exp_on = 1'b1;
        wait_cyc(Q - 1);
        exp_on = 1'b0;
        m_sda = 1'b1;
        wait_cyc(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic ack_exp, input string tag);
        cur_req = tag;
        for (int i = 7; i >= 0; i--) scl_pulse(b[i], 1'b0);
        scl_pulse(1'b1, ack_exp);
    endtask

    task automatic rd_byte(input logic [7:0] eb, input logic m_ack, input string tag);
        cur_req = tag;
        for (int i = 7; i >= 0; i--) scl_pulse(1'b1, ~eb[i]);
        scl_pulse(~m_ack, 1'b0);
    endtask

    task automatic expect_req(input logic [2:0] op, input logic [7:0] d);
        q_op.push_back(op);
        q_dat.push_back(d);
    endtask

    task automatic check_drained(input string tag);
        checks++;
        if (q_op.size() != 0) begin
            errors++;
            $display("FAIL %s pending requests actual %0d expected 0", tag, q_op.size());
        end
        q_op.delete();
        q_dat.delete();
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_sim();
    end

    initial begin
        logic [7:0] wa, ra;
        wa = {my_addr, 1'b0};
        ra = {my_addr, 1'b1};
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);

        // R12: reset state
        checks++;
        if (sda_pull !== 1'b0 || req_valid !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset actual pull %0b req %0b expected 0 0", sda_pull, req_valid);
        end
        // R12: pointer starts at the wiper
        bus_start();
        wr_byte(ra, 1'b1, "R12");
        rd_byte(8'hA5, 1'b0, "R12");
        bus_stop();

        // R4: repeated wiper writes
        bus_start();
        wr_byte(wa, 1'b1, "R2");
        wr_byte(8'h00, 1'b1, "R3");
        expect_req(OP_WIPER_WR, 8'h40);
        wr_byte(8'h40, 1'b1, "R4");
        expect_req(OP_WIPER_WR, 8'h41);
        wr_byte(8'h41, 1'b1, "R4");
        bus_stop();
        check_drained("R4");

        // R5: nonvolatile write
        bus_start();
        wr_byte(wa, 1'b1, "R5");
        wr_byte(8'h20, 1'b1, "R5");
        expect_req(OP_NV_WR, 8'h77);
        wr_byte(8'h77, 1'b1, "R5");
        bus_stop();
        check_drained("R5");

        // R6: write protect uses only bit 0
        bus_start();
        wr_byte(wa, 1'b1, "R6");
        wr_byte(8'h40, 1'b1, "R6");
        expect_req(OP_WP_CLR, 8'h00);
        wr_byte(8'hFE, 1'b1, "R6");
        expect_req(OP_WP_SET, 8'h01);
        wr_byte(8'h01, 1'b1, "R6");
        bus_stop();
        check_drained("R6");

        // R7: store at STOP
        bus_start();
        wr_byte(wa, 1'b1, "R7");
        expect_req(OP_STORE, 8'h00);
        wr_byte(8'hC0, 1'b1, "R7");
        bus_stop();
        check_drained("R7");
        // R7: restore dropped by repeated START; R8: protect register reads 01
        bus_start();
        wr_byte(wa, 1'b1, "R7");
        wr_byte(8'hA0, 1'b1, "R7");
        bus_start();
        wr_byte(ra, 1'b1, "R7");
        rd_byte(8'h01, 1'b0, "R8");
        bus_stop();
        check_drained("R7");

        // R3: invalid instructions are not acknowledged
        bus_start();
        wr_byte(wa, 1'b1, "R3");
        wr_byte(8'h08, 1'b0, "R3");
        wr_byte(8'h40, 1'b0, "R3");
        bus_stop();
        bus_start();
        wr_byte(wa, 1'b1, "R3");
        wr_byte(8'h60, 1'b0, "R3");
        bus_stop();
        check_drained("R3");
        bus_start();
        wr_byte(ra, 1'b1, "R3");
        rd_byte(8'h01, 1'b0, "R3");
        bus_stop();

        // R8: nonvolatile read repeated, R10: release after NACK
        bus_start();
        wr_byte(wa, 1'b1, "R8");
        wr_byte(8'h20, 1'b1, "R8");
        bus_start();
        wr_byte(ra, 1'b1, "R8");
        rd_byte(8'h3C, 1'b1, "R8");
        rd_byte(8'h3C, 1'b0, "R10");
        bus_stop();
        check_drained("R10");
        bus_start();
        wr_byte(wa, 1'b1, "R8");
        wr_byte(8'h00, 1'b1, "R8");
        bus_start();
        wr_byte(ra, 1'b1, "R8");
        rd_byte(8'hA5, 1'b0, "R8");
        bus_stop();

        // R9: tolerance pointer advance
        bus_start();
        wr_byte(wa, 1'b1, "R9");
        wr_byte(8'h3E, 1'b1, "R9");
        bus_start();
        wr_byte(ra, 1'b1, "R9");
        rd_byte(8'h1C, 1'b1, "R9");
        rd_byte(8'h0F, 1'b0, "R9");
        bus_stop();
        bus_start();
        wr_byte(ra, 1'b1, "R9");
        rd_byte(8'h0F, 1'b0, "R9");
        bus_stop();

        // R2: wrong address ignored; R1: START recovers
        bus_start();
        wr_byte({7'h2D, 1'b0}, 1'b0, "R2");
        wr_byte(8'h00, 1'b0, "R2");
        bus_start();
        wr_byte(wa, 1'b1, "R1");
        wr_byte(8'h00, 1'b1, "R1");
        expect_req(OP_WIPER_WR, 8'h22);
        wr_byte(8'h22, 1'b1, "R1");
        bus_stop();
        check_drained("R1");

        // R11: STOP inside a data byte
        bus_start();
        wr_byte(wa, 1'b1, "R11");
        wr_byte(8'h00, 1'b1, "R11");
        cur_req = "R11";
        scl_pulse(1'b1, 1'b0);
        scl_pulse(1'b0, 1'b0);
        scl_pulse(1'b1, 1'b0);
        scl_pulse(1'b0, 1'b0);
        bus_stop();
        wait_cyc(4);
        check_drained("R11");
        bus_start();
        wr_byte(ra, 1'b1, "R11");
        rd_byte(8'hA5, 1'b0, "R11");
        bus_stop();

        wait_cyc(10);
        finish_sim();
    end
endmodule